// File: doc/BRIEF.md
# Frame Pixel Grabber

This block lets a host assemble a complete image of a 15 by 15 sensor array one pixel at a time, through a single 8-bit readable register. Pixels are numbered 0 to 224, running down each column and then on to the next column. While each frame is produced, the array streams out its pixels together with their numbers. The grabber keeps one capture number. In a frame where it is armed, it latches the pixel whose number matches that capture number, and it takes at most one pixel per frame.

The host polls the register. If the top bit is set, the low bits hold a fresh sample. That read also moves the capture number on by one and arms the grabber for the following frame. If the top bit is clear, the read changes nothing. A write with any data starts capture again from pixel 0, beginning with the next frame. After 225 valid reads the host holds the whole image, and the capture number then wraps back to 0.

Top module: `pixel_grabber`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads 0x00 and the capture number is 0.
- R2: Bit 7 of `reg_rdata` is the sample-valid flag. Bits 6:0 carry the captured 7-bit pixel value (0 to 127) unchanged, and this includes the value 0.
- R3: A pixel is latched only in a frame that opened, with a `frame_start` pulse, while no sample was held. It must arrive with `pix_valid` high and `frame_start` low, and its `pix_index` must equal the capture number. Once a pixel is taken, nothing more is taken in that frame. Indexes of 225 and above never match.
- R4: A read (`reg_rd`) while the valid flag is set returns the sample, clears the flag on the next clock, and advances the capture number by one. The next pixel is then taken in a later frame, never in the frame that is still running.
- R5: A read while the valid flag is clear returns 0 in bit 7 and leaves the capture number unchanged.
- R6: While a sample is held and unread, later frames and pixel traffic leave `reg_rdata` unchanged.
- R7: A write (`reg_wr`) clears the valid flag and sets the capture number to 0, whatever the register held. Capture begins with the next `frame_start`, so the rest of the current frame is ignored. A write takes priority over a read in the same cycle.
- R8: A valid read of pixel 224 returns the capture number to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle pulse opening a new frame |
| pix_valid | input | 1 | The pixel stream carries a pixel this cycle |
| pix_index | input | 8 | Number of the streamed pixel (column-major, 0 to 224) |
| pix_data | input | 7 | Value of the streamed pixel |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 8 | Register value: {valid, pixel[6:0]} |

## Verification
`reg_rdata` is decoded directly from registers, so during a read strobe it already shows the value the host receives. The bench samples it there, while the strobe is still high. Every effect of a read, a write or a matching pixel shows up one clock edge after the cycle that carried the stimulus. For that reason the bench drives each stimulus for one cycle starting at a falling edge, and samples at the next falling edge, after exactly one rising edge. The frame arm state is taken at the `frame_start` edge, so the earliest pixel that can be captured is the one presented in the cycle after the pulse. After reset is released, the bench allows three cycles for the synchroniser before making its first check.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int DEF_ROWS  = 15;
  localparam int DEF_COLS  = 15;
  localparam int DEF_PIX_W = 7;

  function automatic int unsigned pix_count(input int unsigned rows, input int unsigned cols);
    return rows * cols;
  endfunction
endpackage

// File: rtl/pg_index_ctr.sv
module pg_index_ctr #(
  parameter int NPIX  = 225,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr | step;
    idx_d  = idx_q;
    if (clr)
      idx_d = '0;
    else if (step)
      idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_en)
      idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/pg_frame_gate.sv
module pg_frame_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic cancel,
  input  logic full,
  input  logic hit,
  output logic take
);
  logic armed_q, armed_d;

  always_comb begin
    take    = armed_q & hit & ~frame_start;
    armed_d = armed_q;
    if (cancel)
      armed_d = 1'b0;
    else if (frame_start)
      armed_d = ~full;
    else if (take)
      armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed_q <= 1'b0;
    else
      armed_q <= armed_d;
  end
endmodule

// File: rtl/pg_sample_hold.sv
module pg_sample_hold #(
  parameter int PIX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             drop,
  input  logic [PIX_W-1:0] pix,
  output logic             full,
  output logic [PIX_W-1:0] value
);
  logic             full_q, full_d;
  logic [PIX_W-1:0] val_q;
  logic             val_en;

  always_comb begin
    full_d = full_q;
    val_en = 1'b0;
    if (drop)
      full_d = 1'b0;
    else if (take) begin
      full_d = 1'b1;
      val_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      full_q <= 1'b0;
    else
      full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val_q <= '0;
    else if (val_en)
      val_q <= pix;
  end

  assign full  = full_q;
  assign value = full_q ? val_q : '0;
endmodule

// File: rtl/pixel_grabber.sv
module pixel_grabber #(
  parameter int ROWS  = pg_pkg::DEF_ROWS,
  parameter int COLS  = pg_pkg::DEF_COLS,
  parameter int PIX_W = pg_pkg::DEF_PIX_W,
  parameter int NPIX  = ROWS * COLS,
  parameter int IDX_W = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_index,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             reg_rd,
  input  logic             reg_wr,
  output logic [PIX_W:0]   reg_rdata
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [IDX_W-1:0] cap_idx;
  logic             full, take, hit, adv, cancel;
  logic [PIX_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    hit    = pix_valid & (pix_index == cap_idx);
    adv    = reg_rd & full & ~reg_wr;
    cancel = reg_wr | adv;
  end

  pg_index_ctr #(.NPIX(NPIX), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_sync_n), .clr(reg_wr), .step(adv), .idx(cap_idx)
  );

  pg_frame_gate u_gate (
    .clk(clk), .rst_n(rst_sync_n), .frame_start(frame_start), .cancel(cancel),
    .full(full), .hit(hit), .take(take)
  );

  pg_sample_hold #(.PIX_W(PIX_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .drop(cancel), .pix(pix_data),
    .full(full), .value(held)
  );

  assign reg_rdata = {full, held};
endmodule

// File: rtl/pixel_grabber_chk.sv
module pixel_grabber_chk #(
  parameter int NPIX  = 225,
  parameter int IDX_W = 8,
  parameter int PIX_W = 7
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             frame_start,
  input logic             pix_valid,
  input logic [IDX_W-1:0] pix_index,
  input logic [PIX_W-1:0] pix_data,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [PIX_W:0]   reg_rdata,
  input logic [IDX_W-1:0] cap_idx
);
  localparam int LAST = NPIX - 1;

  // R1: idle value while reset holds the logic
  a_r1_reset_clear: assert property (@(posedge clk) !rst_ok |-> reg_rdata == '0);

  // R3: the capture number never leaves the pixel range
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_ok)
    int'(cap_idx) < NPIX);

  // R3, R2: a new sample is the matching streamed pixel
  a_r3_capture_match: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(reg_rdata[PIX_W]) |-> ($past(pix_valid) && !$past(frame_start)
      && $past(pix_index) == cap_idx && $past(pix_data) == reg_rdata[PIX_W-1:0]));

  // R4: a valid read drops the flag
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rd && !reg_wr && reg_rdata[PIX_W]) |=> !reg_rdata[PIX_W]);

  // R4, R8: a valid read steps the capture number, wrapping at the end
  a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rd && !reg_wr && reg_rdata[PIX_W]) |=>
      (int'(cap_idx) == ((int'($past(cap_idx)) == LAST) ? 0 : int'($past(cap_idx)) + 1)));

  // R5: an empty read leaves the capture number alone
  a_r5_idle_read: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rd && !reg_wr && !reg_rdata[PIX_W]) |=> $stable(cap_idx));

  // R6: a held sample is not overwritten
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rdata[PIX_W] && !reg_rd && !reg_wr) |=> $stable(reg_rdata));

  // R7: a write restarts from pixel 0 with the flag clear
  a_r7_write_restart: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_wr |=> (!reg_rdata[PIX_W] && cap_idx == '0));
endmodule

bind pixel_grabber pixel_grabber_chk #(.NPIX(NPIX), .IDX_W(IDX_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .frame_start(frame_start), .pix_valid(pix_valid),
  .pix_index(pix_index), .pix_data(pix_data), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .cap_idx(cap_idx)
);

// File: tb/pixel_grabber_test.sv
module pixel_grabber_test;
  localparam int NPIX = 225;
  localparam logic [1:0] OP_FRAME = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2;
  localparam int NV = 15;
  // {op[24:23], index[22:15], data[14:8], expected register[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {OP_FRAME, 8'd0,   7'h15, 8'h95},
    {OP_READ,  8'd0,   7'h00, 8'h95},
    {OP_READ,  8'd0,   7'h00, 8'h00},
    {OP_FRAME, 8'd2,   7'h33, 8'h00},
    {OP_FRAME, 8'd1,   7'h7F, 8'hFF},
    {OP_FRAME, 8'd1,   7'h01, 8'hFF},
    {OP_READ,  8'd0,   7'h00, 8'hFF},
    {OP_WRITE, 8'd0,   7'h00, 8'h00},
    {OP_FRAME, 8'd0,   7'h00, 8'h80},
    {OP_READ,  8'd0,   7'h00, 8'h80},
    {OP_FRAME, 8'd1,   7'h2A, 8'hAA},
    {OP_READ,  8'd0,   7'h00, 8'hAA},
    {OP_FRAME, 8'd200, 7'h05, 8'h00},
    {OP_FRAME, 8'd2,   7'h40, 8'hC0},
    {OP_READ,  8'd0,   7'h00, 8'hC0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, pix_valid = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] pix_index = '0;
  logic [6:0] pix_data = '0;
  logic [7:0] reg_rdata;
  logic [7:0] got;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_grabber uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_index(pix_index), .pix_data(pix_data), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [6:0] pv(input int i);
    return 7'((i * 37 + 5) & 127);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: reg_rdata=%02h expected %02h", req, act, exp);
    end
  endtask

  task automatic frame_pulse();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic pixel(input int i, input logic [6:0] d);
    pix_valid = 1'b1; pix_index = 8'(i); pix_data = d;
    @(negedge clk) pix_valid = 1'b0;
  endtask

  task automatic do_frame(input int i, input logic [6:0] d);
    frame_pulse();
    pixel(i, d);
    #1;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk) reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk) reg_rd = 1'b0;
    #1;
  endtask

  task automatic do_write();
    @(negedge clk) reg_wr = 1'b1;
    @(negedge clk) reg_wr = 1'b0;
    #1;
  endtask

  task automatic apply_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 check("R1 in reset", reg_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset value", reg_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R1 after release", reg_rdata, 8'h00);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      case (VEC[k][24:23])
        OP_FRAME: begin do_frame(int'(VEC[k][22:15]), VEC[k][14:8]); got = reg_rdata; end
        OP_READ:  do_read(got);
        default:  begin do_write(); got = reg_rdata; end
      endcase
      check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", k), got, VEC[k][7:0]);
    end

    // R3: pixel sharing the frame_start cycle is ignored; one pixel per frame after a valid read
    do_write();
    @(negedge clk) frame_start = 1'b1; pix_valid = 1'b1; pix_index = 8'd0; pix_data = 7'h11;
    @(negedge clk) frame_start = 1'b0; pix_valid = 1'b0;
    #1 check("R3 pixel on frame_start cycle", reg_rdata, 8'h00);
    frame_pulse();
    pixel(0, 7'h22);
    #1 check("R3 capture", reg_rdata, 8'hA2);
    do_read(got);
    pixel(1, 7'h33);
    #1 check("R4 no second capture in same frame", reg_rdata, 8'h00);
    do_frame(1, 7'h34);
    check("R4 capture in later frame", reg_rdata, 8'hB4);

    // R7: write mid-frame ignores the rest of that frame
    do_read(got);
    frame_pulse();
    @(negedge clk) reg_wr = 1'b1;
    @(negedge clk) reg_wr = 1'b0;
    pixel(0, 7'h0A);
    #1 check("R7 rest of frame ignored", reg_rdata, 8'h00);
    do_frame(0, 7'h0B);
    check("R7 restart at pixel 0", reg_rdata, 8'h8B);

    // R7: write beats read in the same cycle (index stays 0)
    @(negedge clk) reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk) reg_wr = 1'b0; reg_rd = 1'b0;
    #1 check("R7 write with read clears", reg_rdata, 8'h00);
    do_frame(1, 7'h0C);
    check("R7 index not advanced by read", reg_rdata, 8'h00);
    do_frame(0, 7'h0D);
    check("R7 pixel 0 after write+read", reg_rdata, 8'h8D);

    // R8: full image then wrap
    do_write();
    for (int i = 0; i < NPIX; i++) begin
      frame_pulse();
      pixel(i + 1, 7'h7F);
      pixel(i, pv(i));
      do_read(got);
      check($sformatf("R8 image pixel %0d", i), got, {1'b1, pv(i)});
    end
    frame_pulse();
    pixel(225, 7'h7E);
    #1 check("R3 index 225 never matches", reg_rdata, 8'h00);
    pixel(0, pv(0));
    #1 check("R8 wrap to pixel 0", reg_rdata, {1'b1, pv(0)});

    // R1: reset while a sample is held
    apply_reset();
    check("R1 reset clears held sample", reg_rdata, 8'h00);
    do_frame(0, 7'h44);
    check("R1 index 0 after reset", reg_rdata, 8'hC4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule